// File: doc/BRIEF.md
# DRAM Bank Timing Constraint Enforcer

This block sits in front of a DRAM command scheduler and answers one question each cycle: may the requested command (activate, read, write or precharge) go to the requested bank right now? It keeps a small set of down-counters for each of four banks and two shared counters. From these it raises a combinational grant for the presented request only once every minimum interval since earlier commands has passed. When the scheduler actually issues a granted command, the block loads the counters that the command starts.

All interval lengths come from one packed 32-bit configuration word. Its fields use compact and partly irregular codes: one field is non-monotonic, and two fields have a reserved code. The block decodes them to cycle counts every cycle. A reserved code, or any set bit in the unused upper half, latches a sticky configuration-error flag. The affected field then falls back to its largest legal value. The column-access latency is not enforced. It is only decoded and exported as a read-data-valid delay counted in half cycles, for a downstream capture stage.

Top module: `dram_bank_timer`

## Requirements
- R1: Activate-to-column delay, field bits [1:0], codes 0,1,2,3 give 1,2,3,4 cycles. A read or write to a bank is first granted exactly that many cycles after the activate to that bank.
- R2: Precharge time, field bits [3:2], codes 0,1,2,3 give 3,2,1,4 cycles. An activate to a bank is first granted that many cycles after its precharge, once the other activate limits are met.
- R3: Minimum active time, field bits [6:4], code c gives c+2 cycles. A precharge is first granted that many cycles after the activate to the same bank.
- R4: Same-bank activate-to-activate time, field bits [9:7], code c gives c+3 cycles. It is measured from one activate of a bank to the next activate of that bank.
- R5: Cross-bank activate gap, field bit [10], 0 gives 2 cycles and 1 gives 3 cycles. It applies after any activate, to an activate on any bank.
- R6: Write recovery, field bits [12:11], codes 00, 10 and 11 give 1, 2 and 3 cycles. A precharge to a bank is held off for that many cycles after a write to it.
- R7: Write-to-read delay, field bit [13], 0 gives 1 cycle and 1 gives 2 cycles. It is measured from any write to a read on any bank.
- R8: Column latency, field bits [15:14], codes 00, 01 and 10 mean 3, 2 and 2.5 cycles. The block outputs them on rd_data_delay as 6, 4 and 5 half-cycles.
- R9: Write-recovery code 01, latency code 11, or any set bit in [31:16] sets cfg_err one cycle later. The flag stays set until reset, and the fallback values are 3 cycles of write recovery and 6 half-cycles of latency.
- R10: Command encoding is 0 activate, 1 read, 2 write, 3 precharge. An activate is only granted to a closed bank. A read, write or precharge is only granted to an open bank.
- R11: grant is low whenever req_valid is low. A command takes effect only when req_valid, req_issue and grant are all high. Any other issue attempt changes no state.
- R12: After reset all banks are closed, all intervals have expired and cfg_err is 0, so an activate to any bank is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Packed timing configuration |
| req_valid | input | 1 | A request is presented |
| req_cmd | input | 2 | Requested command code |
| req_bank | input | 2 | Requested bank index |
| req_issue | input | 1 | Scheduler issues the request this cycle if granted |
| grant | output | 1 | Request may issue this cycle |
| cfg_err | output | 1 | Sticky configuration error |
| rd_data_delay | output | 3 | Read-data-valid delay in half cycles |

## Verification
The grant is combinational from registered counters and the current request. A command issued in cycle 0 therefore yields a dependent grant first in cycle N, where N is the decoded interval. The bench drives inputs on the falling edge and samples grant shortly after. It issues the first command, then presents the dependent request without issuing it, once per cycle, and compares the index of the first granted cycle with the arithmetically decoded value for every field code. cfg_err is due one cycle after a reserved code appears, and rd_data_delay in the same cycle as the configuration change. The bench samples both at those points.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    localparam int TW = 4;

    localparam int F_RCD = 0;
    localparam int F_RP  = 2;
    localparam int F_RAS = 4;
    localparam int F_RC  = 7;
    localparam int F_RRD = 10;
    localparam int F_WR  = 11;
    localparam int F_WTR = 13;
    localparam int F_CL  = 14;
    localparam int F_TOP = 16;

    typedef struct packed {
        logic [TW-1:0] rcd;
        logic [TW-1:0] rp;
        logic [TW-1:0] ras;
        logic [TW-1:0] rc;
        logic [TW-1:0] rrd;
        logic [TW-1:0] wr;
        logic [TW-1:0] wtr;
    } timing_t;

    function automatic logic [TW-1:0] dec_sat(input logic [TW-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

endpackage

// File: rtl/dbt_cfg_decode.sv
module dbt_cfg_decode
    import dbt_pkg::*;
(
    input  logic [31:0]   cfg,
    output timing_t       tim,
    output logic [2:0]    cl_half,
    output logic          bad_code
);
    always_comb begin
        tim.rcd = {2'b00, cfg[F_RCD +: 2]} + 4'd1;
        tim.ras = {1'b0, cfg[F_RAS +: 3]} + 4'd2;
        tim.rc  = {1'b0, cfg[F_RC  +: 3]} + 4'd3;
        tim.rrd = cfg[F_RRD] ? 4'd3 : 4'd2;
        tim.wtr = cfg[F_WTR] ? 4'd2 : 4'd1;

        unique case (cfg[F_RP +: 2])
            2'b00:   tim.rp = 4'd3;
            2'b01:   tim.rp = 4'd2;
            2'b10:   tim.rp = 4'd1;
            default: tim.rp = 4'd4;
        endcase

        unique case (cfg[F_WR +: 2])
            2'b00:   tim.wr = 4'd1;
            2'b10:   tim.wr = 4'd2;
            default: tim.wr = 4'd3;
        endcase

        unique case (cfg[F_CL +: 2])
            2'b01:   cl_half = 3'd4;
            2'b10:   cl_half = 3'd5;
            default: cl_half = 3'd6;
        endcase

        bad_code = (cfg[F_WR +: 2] == 2'b01)
                 | (cfg[F_CL +: 2] == 2'b11)
                 | (|cfg[31:F_TOP]);
    end
endmodule

// File: rtl/dbt_bank_ctr.sv
module dbt_bank_ctr
    import dbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  timing_t tim,
    input  logic    do_act,
    input  logic    do_wr,
    input  logic    do_pre,
    output logic    is_open,
    output logic    col_ok,
    output logic    pre_ok,
    output logic    act_ok
);
    typedef struct packed {
        logic          open;
        logic [TW-1:0] rcd;
        logic [TW-1:0] ras;
        logic [TW-1:0] rc;
        logic [TW-1:0] rp;
        logic [TW-1:0] wr;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rcd = dec_sat(st_q.rcd);
        st_d.ras = dec_sat(st_q.ras);
        st_d.rc  = dec_sat(st_q.rc);
        st_d.rp  = dec_sat(st_q.rp);
        st_d.wr  = dec_sat(st_q.wr);
        if (do_act) begin
            st_d.open = 1'b1;
            st_d.rcd  = tim.rcd - 1'b1;
            st_d.ras  = tim.ras - 1'b1;
            st_d.rc   = tim.rc  - 1'b1;
        end
        if (do_wr) begin
            st_d.wr = tim.wr - 1'b1;
        end
        if (do_pre) begin
            st_d.open = 1'b0;
            st_d.rp   = tim.rp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open = st_q.open;
    assign col_ok  = (st_q.rcd == '0);
    assign pre_ok  = (st_q.ras == '0) && (st_q.wr == '0);
    assign act_ok  = (st_q.rp == '0) && (st_q.rc == '0);
endmodule

// File: rtl/dbt_cross_ctr.sv
module dbt_cross_ctr
    import dbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  timing_t tim,
    input  logic    any_act,
    input  logic    any_wr,
    output logic    gap_ok,
    output logic    rd_ok
);
    typedef struct packed {
        logic [TW-1:0] rrd;
        logic [TW-1:0] wtr;
    } cross_st_t;

    cross_st_t st_d, st_q;

    always_comb begin
        st_d.rrd = any_act ? tim.rrd - 1'b1 : dec_sat(st_q.rrd);
        st_d.wtr = any_wr  ? tim.wtr - 1'b1 : dec_sat(st_q.wtr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gap_ok = (st_q.rrd == '0);
    assign rd_ok  = (st_q.wtr == '0);
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_issue,
    output logic              grant,
    output logic              cfg_err,
    output logic [2:0]        rd_data_delay
);
    timing_t tim;
    logic    bad_code;
    logic    err_d, err_q;
    logic    take;
    cmd_e    cmd;

    logic [NUM_BANKS-1:0] b_open, b_col_ok, b_pre_ok, b_act_ok;
    logic [NUM_BANKS-1:0] b_act, b_wr, b_pre;
    logic                 gap_ok, rd_ok;

    assign cmd = cmd_e'(req_cmd);

    dbt_cfg_decode u_dec (
        .cfg      (cfg_word),
        .tim      (tim),
        .cl_half  (rd_data_delay),
        .bad_code (bad_code)
    );

    assign take = req_valid & req_issue & grant;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign b_act[i] = take && (cmd == CMD_ACT) && (req_bank == BANK_W'(i));
        assign b_wr[i]  = take && (cmd == CMD_WR)  && (req_bank == BANK_W'(i));
        assign b_pre[i] = take && (cmd == CMD_PRE) && (req_bank == BANK_W'(i));

        dbt_bank_ctr u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .tim     (tim),
            .do_act  (b_act[i]),
            .do_wr   (b_wr[i]),
            .do_pre  (b_pre[i]),
            .is_open (b_open[i]),
            .col_ok  (b_col_ok[i]),
            .pre_ok  (b_pre_ok[i]),
            .act_ok  (b_act_ok[i])
        );
    end

    dbt_cross_ctr u_cross (
        .clk     (clk),
        .rst_n   (rst_n),
        .tim     (tim),
        .any_act (|b_act),
        .any_wr  (|b_wr),
        .gap_ok  (gap_ok),
        .rd_ok   (rd_ok)
    );

    always_comb begin
        logic ok;
        unique case (cmd)
            CMD_ACT: ok = !b_open[req_bank] && b_act_ok[req_bank] && gap_ok;
            CMD_RD:  ok = b_open[req_bank] && b_col_ok[req_bank] && rd_ok;
            CMD_WR:  ok = b_open[req_bank] && b_col_ok[req_bank];
            default: ok = b_open[req_bank] && b_pre_ok[req_bank];
        endcase
        grant = req_valid && ok;
    end

    always_comb begin
        err_d = err_q | bad_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign cfg_err = err_q;
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker
    import dbt_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       cfg_word,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [BANK_W-1:0] req_bank,
    input logic              req_issue,
    input logic              grant,
    input logic              cfg_err,
    input logic [2:0]        rd_data_delay
);
    logic fired, reserved_seen;
    assign fired = req_valid && req_issue && grant;
    assign reserved_seen = (cfg_word[F_WR +: 2] == 2'b01)
                         || (cfg_word[F_CL +: 2] == 2'b11)
                         || (cfg_word[31:F_TOP] != '0);

    assert_grant_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !grant);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_err_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_seen |=> cfg_err);

    assert_no_reopen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && req_cmd == 2'd0) |=>
        !(req_valid && req_cmd == 2'd0 && req_bank == $past(req_bank) && grant));

    assert_act_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && req_cmd == 2'd0) |=> !(req_valid && req_cmd == 2'd0 && grant));

    assert_closed_no_column_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && req_cmd == 2'd3) |=>
        !(req_valid && (req_cmd == 2'd1 || req_cmd == 2'd2)
          && req_bank == $past(req_bank) && grant));

    assert_latency_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_delay >= 3'd4) && (rd_data_delay <= 3'd6));
endmodule

bind dram_bank_timer dbt_checker #(.BANK_W(BANK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_word      (cfg_word),
    .req_valid     (req_valid),
    .req_cmd       (req_cmd),
    .req_bank      (req_bank),
    .req_issue     (req_issue),
    .grant         (grant),
    .cfg_err       (cfg_err),
    .rd_data_delay (rd_data_delay)
);

// File: tb/dram_bank_timer_tb.sv
module dram_bank_timer_tb_top;
    localparam int CLK_P = 10;
    localparam logic [1:0] ACT = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'd0;
    logic [1:0]  req_bank = 2'd0;
    logic        req_issue = 1'b0;
    logic        grant, cfg_err;
    logic [2:0]  rd_data_delay;

    int vec = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dram_bank_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_issue(req_issue), .grant(grant), .cfg_err(cfg_err),
        .rd_data_delay(rd_data_delay)
    );

    function automatic logic [31:0] mk(int rcd, int rp, int ras, int rc, int rrd,
                                       int wr, int wtr, int cl);
        logic [31:0] w = '0;
        w[1:0]   = 2'(rcd);
        w[3:2]   = 2'(rp);
        w[6:4]   = 3'(ras);
        w[9:7]   = 3'(rc);
        w[10]    = 1'(rrd);
        w[12:11] = 2'(wr);
        w[13]    = 1'(wtr);
        w[15:14] = 2'(cl);
        return w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] c, input logic [1:0] b,
                        input logic iss, output logic g);
        @(negedge clk);
        req_valid = v; req_cmd = c; req_bank = b; req_issue = iss;
        #1;
        g = grant;
    endtask

    task automatic idle(input int n);
        logic g;
        for (int i = 0; i < n; i++) step(1'b0, ACT, 2'd0, 1'b0, g);
    endtask

    task automatic do_reset(input logic [31:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_word = cfg;
        req_valid = 1'b0; req_issue = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [1:0] c, input logic [1:0] b, input string tag);
        logic g;
        step(1'b1, c, b, 1'b1, g);
        chk(tag, int'(g), 1);
    endtask

    task automatic probe(input logic [1:0] c, input logic [1:0] b, output int k);
        logic g;
        k = 99;
        for (int i = 1; i <= 30; i++) begin
            step(1'b1, c, b, 1'b0, g);
            if (g) begin k = i; break; end
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int k;
        logic g;

        // R12: reset state
        do_reset(mk(0,0,0,0,0,0,0,0));
        for (int b = 0; b < 4; b++) begin
            step(1'b1, ACT, 2'(b), 1'b0, g);
            chk("R12 act granted after reset", int'(g), 1);
        end
        chk("R12 cfg_err after reset", int'(cfg_err), 0);

        // R10: column and precharge to closed bank refused
        step(1'b1, RD, 2'd2, 1'b0, g);  chk("R10 read closed", int'(g), 0);
        step(1'b1, PRE, 2'd2, 1'b0, g); chk("R10 pre closed", int'(g), 0);

        // R11: no valid -> no grant and no effect
        step(1'b0, ACT, 2'd0, 1'b1, g); chk("R11 grant without valid", int'(g), 0);
        step(1'b1, ACT, 2'd1, 1'b0, g); chk("R11 no gap after invalid issue", int'(g), 1);
        step(1'b1, WR, 2'd3, 1'b1, g);  chk("R11 refused write", int'(g), 0);
        step(1'b1, ACT, 2'd3, 1'b0, g); chk("R11 bank stays closed", int'(g), 1);

        // R1: activate to column delay
        for (int c = 0; c < 4; c++) begin
            do_reset(mk(c,0,0,0,0,0,0,0));
            issue(ACT, 2'd0, "R1 act");
            probe(RD, 2'd0, k);
            chk("R1 read latency", k, c + 1);
            do_reset(mk(c,0,0,0,0,0,0,0));
            issue(ACT, 2'd1, "R1 act");
            probe(WR, 2'd1, k);
            chk("R1 write latency", k, c + 1);
        end

        // R2: precharge time, non-monotonic code
        for (int c = 0; c < 4; c++) begin
            do_reset(mk(0,c,0,0,0,0,0,0));
            issue(ACT, 2'd2, "R2 act");
            idle(12);
            issue(PRE, 2'd2, "R2 pre");
            probe(ACT, 2'd2, k);
            chk("R2 precharge latency", k, (c == 0) ? 3 : (c == 1) ? 2 : (c == 2) ? 1 : 4);
        end

        // R3: minimum active time
        for (int c = 0; c < 8; c++) begin
            do_reset(mk(0,0,c,0,0,0,0,0));
            issue(ACT, 2'd0, "R3 act");
            probe(PRE, 2'd0, k);
            chk("R3 active latency", k, c + 2);
        end

        // R4: same-bank activate cycle
        for (int c = 0; c < 8; c++) begin
            do_reset(mk(0,2,0,c,0,0,0,0));
            issue(ACT, 2'd3, "R4 act");
            idle(1);
            issue(PRE, 2'd3, "R4 pre");
            probe(ACT, 2'd3, k);
            chk("R4 row cycle latency", k + 2, c + 3);
        end

        // R5: cross-bank activate gap
        for (int c = 0; c < 2; c++) begin
            do_reset(mk(0,0,0,0,c,0,0,0));
            issue(ACT, 2'd0, "R5 act");
            probe(ACT, 2'd1, k);
            chk("R5 gap latency", k, c + 2);
        end

        // R6 and R9: write recovery, reserved code falls back to 3
        for (int c = 0; c < 4; c++) begin
            do_reset(mk(0,0,0,0,0,c,0,0));
            issue(ACT, 2'd1, "R6 act");
            issue(WR, 2'd1, "R6 write");
            probe(PRE, 2'd1, k);
            chk((c == 1) ? "R9 reserved recovery" : "R6 recovery latency", k,
                (c == 0) ? 1 : (c == 2) ? 2 : 3);
        end

        // R7: write to read, same and other bank
        for (int c = 0; c < 2; c++) begin
            do_reset(mk(0,0,0,0,0,0,c,0));
            issue(ACT, 2'd0, "R7 act");
            issue(WR, 2'd0, "R7 write");
            probe(RD, 2'd0, k);
            chk("R7 same bank latency", k, c + 1);
            do_reset(mk(0,0,0,0,0,0,c,0));
            issue(ACT, 2'd0, "R7 act");
            idle(1);
            issue(ACT, 2'd1, "R7 act");
            issue(WR, 2'd0, "R7 write");
            probe(RD, 2'd1, k);
            chk("R7 cross bank latency", k, c + 1);
        end

        // R8: latency export in half cycles
        do_reset(mk(0,0,0,0,0,0,0,0));
        for (int c = 0; c < 3; c++) begin
            cfg_word = mk(0,0,0,0,0,0,0,c);
            #1;
            chk("R8 latency half cycles", int'(rd_data_delay), (c == 0) ? 6 : (c == 1) ? 4 : 5);
        end
        chk("R8 no error on legal codes", int'(cfg_err), 0);

        // R9: reserved latency, sticky flag, upper bits
        do_reset(mk(0,0,0,0,0,0,0,0));
        idle(1);
        cfg_word = mk(0,0,0,0,0,0,0,3);
        #1;
        chk("R9 reserved latency fallback", int'(rd_data_delay), 6);
        chk("R9 flag not yet set", int'(cfg_err), 0);
        idle(1);
        chk("R9 flag set", int'(cfg_err), 1);
        cfg_word = mk(0,0,0,0,0,0,0,1);
        idle(3);
        chk("R9 flag sticky", int'(cfg_err), 1);
        do_reset(mk(0,0,0,0,0,0,0,0));
        idle(1);
        chk("R9 flag cleared by reset", int'(cfg_err), 0);
        cfg_word = 32'h0001_0000;
        idle(1);
        chk("R9 upper bits flag", int'(cfg_err), 1);

        // R10: open bank refuses a second activate
        do_reset(mk(0,0,0,0,0,0,0,0));
        issue(ACT, 2'd2, "R10 act");
        idle(12);
        step(1'b1, ACT, 2'd2, 1'b0, g);
        chk("R10 open bank activate", int'(g), 0);
        step(1'b1, PRE, 2'd2, 1'b0, g);
        chk("R10 open bank precharge", int'(g), 1);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule